// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (I2C)

This block is the serial configuration port of a clock generator. It holds six 8-bit control registers whose contents drive the synthesis logic as parallel outputs. A bus controller reaches the registers over a two-wire I2C bus. The block samples SCL and SDA with a fast system clock, so it needs no separate bus-clock domain.

A write starts with the device address byte 0xD2. The two bytes that follow are acknowledged and then dropped. Each later byte is stored in the next register, starting at register 0. There is no register pointer: every write begins again at register 0.

A read uses address 0xD3. The slave first returns a byte count and then the six registers, in ascending order. The slave pulls SDA low through an active-low drive enable for an open-drain pad.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, registers 0 to 4 read 0xFF, register 5 reads 0x06 (bits 7..3 and 0 clear, bits 2 and 1 set), and `sda_drive_n` is 1 (released).
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low during the ninth clock. For any other address byte it does not acknowledge, and it ignores the rest of that transfer until the next START or STOP.
- R3: In a write, the slave acknowledges the two bytes after the address and discards their contents. It then stores each acknowledged data byte in registers 0, 1, 2 and so on, in that order.
- R4: A STOP after any complete data byte ends the write. Registers already written keep their new values, and the others keep their old values.
- R5: In a write, data bytes beyond register 5 are acknowledged and change no register.
- R6: In a read, the slave sends the byte count 6 and then registers 0 to 5 in ascending order. Every byte is sent MSB first, and each byte follows a controller acknowledge.
- R7: When the controller does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP. Further clocks in that transfer read as all ones.
- R8: A START or STOP in the middle of a byte aborts the transfer, and the partial byte is not stored. A repeated START begins a new address phase.
- R9: The slave changes `sda_drive_n` only while SCL is low.
- R10: A low pulse on SCL of one system clock is filtered out and does not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (resolved wired-AND level) |
| sda_drive_n | output | 1 | Active-low drive enable for the open-drain SDA pad (0 pulls SDA low) |
| cfg_regs | output | NUM_REGS*8 | Register contents; register i occupies bits [8i+7:8i] |

## Verification
Each bus line passes through a two-flop synchronizer and a four-cycle filter, so the slave reacts to an SCL edge about seven system clocks after that edge. The bench holds each quarter of a bus bit for 20 system clocks. As a result, the slave's acknowledge and data drive are settled well before the bench samples the wired line, which it does halfway through the SCL high phase. The register outputs change one clock after the slave detects the falling SCL edge that ends a data byte. The bench checks the registers only after the STOP and a settle wait. A separate monitor flags any change of the drive enable while the bench holds SCL high.

// File: rtl/clkcfg_i2c_pkg.sv
package clkcfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } bus_state_t;

  localparam logic [7:0] FILL_DEFAULT = 8'hFF;
  localparam logic [7:0] LAST_DEFAULT = 8'h06;

  function automatic logic [7:0] reg_default(input int idx, input int nregs);
    return (idx == nregs - 1) ? LAST_DEFAULT : FILL_DEFAULT;
  endfunction

endpackage

// File: rtl/clkcfg_line_filter.sv
module clkcfg_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic          meta_q, sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_q != filt_q) begin
      if (cnt_q == CNT_LAST) begin
        filt_d = sync_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int TIDXW    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TIDXW-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [TIDXW-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(i, NUM_REGS);
    logic sel;
    assign sel = wr_en && (wr_idx == TIDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= DEF;
      end else if (sel) begin
        regs_q[i] <= wr_data;
      end
    end
    assign regs_o[i*8 +: 8] = regs_q[i];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == TIDXW'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
  import clkcfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         TIDXW    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_f,
  input  logic [7:0]       rd_data,
  output logic [TIDXW-1:0] rd_idx,
  output logic             wr_en,
  output logic [TIDXW-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_drive_n
);
  localparam int              BIW       = $clog2(NUM_REGS + 3);
  localparam logic [BIW-1:0]  BI_FIRST  = BIW'(2);
  localparam logic [BIW-1:0]  BI_MAX    = BIW'(NUM_REGS + 2);
  localparam logic [TIDXW-1:0] TX_MAX   = TIDXW'(NUM_REGS);
  localparam logic [7:0]      BYTE_CNT  = 8'(NUM_REGS);

  bus_state_t       state_q, state_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [BIW-1:0]   bidx_q, bidx_d;
  logic [TIDXW-1:0] tidx_q, tidx_d;
  logic             addr_ph_q, addr_ph_d;
  logic             rw_q, rw_d;
  logic             mack_q, mack_d;
  logic             drv_n_q, drv_n_d;
  logic             wen_q, wen_d;
  logic [TIDXW-1:0] widx_q, widx_d;
  logic [7:0]       wdat_q, wdat_d;
  logic [7:0]       load_byte;

  assign load_byte = (tidx_q < TX_MAX) ? rd_data : 8'hFF;

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    bidx_d    = bidx_q;
    tidx_d    = tidx_q;
    addr_ph_d = addr_ph_q;
    rw_d      = rw_q;
    mack_d    = mack_q;
    drv_n_d   = drv_n_q;
    wen_d     = 1'b0;
    widx_d    = widx_q;
    wdat_d    = wdat_q;
    if (start_det) begin
      state_d   = ST_RX;
      bit_d     = '0;
      addr_ph_d = 1'b1;
      drv_n_d   = 1'b1;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      drv_n_d = 1'b1;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (addr_ph_q) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_d   = ST_ACK;
                drv_n_d   = 1'b0;
                rw_d      = sh_q[0];
                addr_ph_d = 1'b0;
                bidx_d    = '0;
                tidx_d    = '0;
              end else begin
                state_d = ST_WAIT;
              end
            end else begin
              state_d = ST_ACK;
              drv_n_d = 1'b0;
              if (bidx_q >= BI_FIRST && bidx_q < BI_MAX) begin
                wen_d  = 1'b1;
                widx_d = TIDXW'(bidx_q - BI_FIRST);
                wdat_d = sh_q;
              end
              if (bidx_q != BI_MAX) bidx_d = bidx_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              state_d = ST_TX;
              sh_d    = BYTE_CNT;
              drv_n_d = BYTE_CNT[7];
            end else begin
              state_d = ST_RX;
              drv_n_d = 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              state_d = ST_TXACK;
              drv_n_d = 1'b1;
            end else begin
              sh_d    = {sh_q[6:0], 1'b1};
              drv_n_d = sh_q[6];
              bit_d   = bit_q + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_TX;
              bit_d   = '0;
              sh_d    = load_byte;
              drv_n_d = load_byte[7];
              if (tidx_q != TX_MAX) tidx_d = tidx_q + 1'b1;
            end else begin
              state_d = ST_WAIT;
              drv_n_d = 1'b1;
            end
          end
        end
        default: begin
          drv_n_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      bidx_q    <= '0;
      tidx_q    <= '0;
      addr_ph_q <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      drv_n_q   <= 1'b1;
      wen_q     <= 1'b0;
      widx_q    <= '0;
      wdat_q    <= '0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      bidx_q    <= bidx_d;
      tidx_q    <= tidx_d;
      addr_ph_q <= addr_ph_d;
      rw_q      <= rw_d;
      mack_q    <= mack_d;
      drv_n_q   <= drv_n_d;
      wen_q     <= wen_d;
      widx_q    <= widx_d;
      wdat_q    <= wdat_d;
    end
  end

  assign rd_idx      = tidx_q;
  assign wr_en       = wen_q;
  assign wr_idx      = widx_q;
  assign wr_data     = wdat_q;
  assign sda_drive_n = drv_n_q;
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         FILT_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_n,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  localparam int TIDXW = $clog2(NUM_REGS + 1);

  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    clkcfg_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  logic scl_filt, sda_filt, scl_prev, sda_prev;
  assign scl_filt = filt_lines[1];
  assign sda_filt = filt_lines[0];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_filt;
      sda_prev <= sda_filt;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_filt & ~scl_prev;
  assign scl_fall  = ~scl_filt & scl_prev;
  assign start_det = scl_filt & scl_prev & sda_prev & ~sda_filt;
  assign stop_det  = scl_filt & scl_prev & ~sda_prev & sda_filt;

  logic             wr_en;
  logic [TIDXW-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  clkcfg_bus_fsm #(
    .NUM_REGS (NUM_REGS),
    .DEV_ADDR (DEV_ADDR),
    .TIDXW    (TIDXW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_f       (sda_filt),
    .rd_data     (rd_data),
    .rd_idx      (rd_idx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .sda_drive_n (sda_drive_n)
  );

  clkcfg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .TIDXW    (TIDXW)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (cfg_regs)
  );
endmodule

// File: rtl/clkcfg_i2c_chk.sv
module clkcfg_i2c_chk (
  input logic clk,
  input logic rst_q_n,
  input logic scl_f,
  input logic sda_drive_n,
  input logic wr_en,
  input logic start_det,
  input logic stop_det
);
  // R1
  rst_release_chk: assert property (@(posedge clk)
    $rose(rst_q_n) |-> sda_drive_n);

  // R9
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(sda_drive_n) |-> !scl_f);

  // R3
  single_store_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_en |=> !wr_en);

  // R8
  cond_release_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_det || stop_det) |=> sda_drive_n);

  // R8
  no_store_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_det || stop_det) |=> !wr_en);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .scl_f       (scl_filt),
  .sda_drive_n (sda_drive_n),
  .wr_en       (wr_en),
  .start_det   (start_det),
  .stop_det    (stop_det)
);

// File: tb/clkcfg_i2c_slave_test.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave_test;
  localparam int NREG = 6;
  localparam int Q    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_drive_n;
  logic [NREG*8-1:0] cfg_regs;
  logic sda_line;
  logic glitch_en = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int r9_viol  = 0;
  logic [7:0] shadow [NREG];

  always #2 clk = ~clk;

  assign sda_line = m_sda & sda_drive_n;

  clkcfg_i2c_slave uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .sda_drive_n (sda_drive_n),
    .cfg_regs    (cfg_regs)
  );

  // R9 monitor: drive enable must not move while SCL is held high
  logic prev_drv = 1'b1;
  always @(negedge clk) begin
    if (rst_n && (sda_drive_n != prev_drv) && m_scl) r9_viol++;
    prev_drv <= sda_drive_n;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(Q);
    if (glitch_en) begin
      m_scl = 1'b0; wq(1);
      m_scl = 1'b1;
    end
    seen = sda_line; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, cfg_regs[i*8 +: 8], shadow[i]);
  endtask

  // write header: address, dummy command, dummy count
  task automatic write_head(input string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk({req, " addr ack"}, a, 1'b1);
    send_byte(8'h5A, a); chk({req, " cmd ack"}, a, 1'b1);
    send_byte(8'h77, a); chk({req, " cnt ack"}, a, 1'b1);
  endtask

  task automatic t_reset();
    wq(10);
    for (int i = 0; i < NREG; i++) shadow[i] = (i == NREG - 1) ? 8'h06 : 8'hFF;
    check_regs("R1 reset value");
    chk("R1 sda released", sda_drive_n, 1'b1);
  endtask

  task automatic t_full_write();
    logic a;
    write_head("R3");
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'(8'h11 * (i + 1)), a);
      chk("R3 data ack", a, 1'b1);
      shadow[i] = 8'(8'h11 * (i + 1));
    end
    bus_stop(); wq(20);
    check_regs("R3 stored in order");
  endtask

  task automatic t_partial_write();
    logic a;
    write_head("R4");
    send_byte(8'hAA, a); shadow[0] = 8'hAA;
    send_byte(8'hBB, a); shadow[1] = 8'hBB;
    bus_stop(); wq(20);
    check_regs("R4 partial write");
  endtask

  task automatic t_overflow();
    logic a;
    write_head("R5");
    for (int i = 0; i < NREG + 2; i++) begin
      send_byte(8'(i + 1), a);
      chk("R5 every data byte acked", a, 1'b1);
      if (i < NREG) shadow[i] = 8'(i + 1);
    end
    bus_stop(); wq(20);
    check_regs("R5 extra bytes ignored");
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign address not acked", a, 1'b0);
    send_byte(8'h00, a); chk("R2 following byte not acked", a, 1'b0);
    send_byte(8'h00, a);
    send_byte(8'hFE, a); chk("R2 data not acked", a, 1'b0);
    bus_stop(); wq(20);
    check_regs("R2 no change after foreign address");
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a); chk("R2 read address acked", a, 1'b1);
    recv_byte(1'b1, d);  chk("R6 byte count", d, 8'd6);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i != NREG - 1, d);
      chk("R6 register read", d, shadow[i]);
    end
    bus_stop(); wq(20);
    chk("R7 released after final nack", sda_drive_n, 1'b1);
  endtask

  task automatic t_early_nack();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, d);
    recv_byte(1'b0, d); chk("R7 first register", d, shadow[0]);
    recv_byte(1'b0, d); chk("R7 bus idle ones after nack", d, 8'hFF);
    chk("R7 drive released", sda_drive_n, 1'b1);
    bus_stop(); wq(20);
  endtask

  task automatic t_abort();
    logic a, s;
    write_head("R8");
    send_byte(8'h9C, a); shadow[0] = 8'h9C;
    bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b0, s);
    bus_stop(); wq(20);
    check_regs("R8 stop mid-byte");
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_bit(1'b0, s); bus_bit(1'b1, s);
    bus_start();
    send_byte(8'hD2, a); chk("R8 repeated start address ack", a, 1'b1);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h3C, a); shadow[0] = 8'h3C;
    bus_stop(); wq(20);
    check_regs("R8 after repeated start");
  endtask

  task automatic t_glitch();
    logic a;
    glitch_en = 1'b1;
    write_head("R10");
    send_byte(8'hA5, a); shadow[0] = 8'hA5;
    send_byte(8'h5A, a); shadow[1] = 8'h5A;
    chk("R10 ack under glitches", a, 1'b1);
    bus_stop(); wq(20);
    glitch_en = 1'b0;
    check_regs("R10 data intact under glitches");
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    t_reset();
    t_full_write();
    t_partial_write();
    t_overflow();
    t_bad_addr();
    t_read();
    t_early_nack();
    t_abort();
    t_glitch();
    chk("R9 drive changed while SCL high", r9_viol, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule